// File: doc/BRIEF.md
# Banked Control-Register SPI Target

This block is the command engine of a byte-oriented SPI target. A serial shifter outside the block marks the start of a transaction when chip select falls. It delivers each received MOSI byte with a one-cycle strobe and marks the end when chip select rises. The block reads the first byte of each frame as a command header. The top three bits select the operation and the low five bits select a register address. The block then carries out register reads, register writes, bit-set and bit-clear read-modify-write operations, buffer transfers and a soft reset. It also prepares, in `tx_byte`, the byte the shifter sends on MISO during the next byte period.

Register storage has several banks of 32 byte-wide locations. The top five addresses are the same physical registers in every bank. The low bits of the register at address 0x1F choose the bank that the lower addresses refer to. Some banked locations belong to a slow class. Reads of that class insert a dummy byte before the value, and bit-set and bit-clear leave that class untouched. Bank 0 also holds the two pointers of a small byte buffer. Buffer transfers move through the buffer one byte per data byte, and the pointers wrap at the end of the buffer.

Top module: `spibank_regfile`

## Requirements
- R1: After reset `tx_byte` is 0x00 and every register reads 0x00. `tx_byte` changes only in the cycle after an accepted byte strobe. A byte strobed outside a frame (no `cs_fall` since the last `cs_rise`) changes neither `tx_byte` nor any register, pointer or buffer entry.
- R2: Header bits [7:5] are the opcode and bits [4:0] are the address. Opcode 000 reads a register, 010 writes one, 100 sets bits and 101 clears bits. Opcode 001 is a buffer read only when the header is exactly 0x3A, and 011 is a buffer write only when it is exactly 0x7A. Opcode 111 is a reset only when the header is exactly 0xFF. Any other header (including opcode 110) makes the whole frame inert, and `tx_byte` is 0x00 for the rest of that frame.
- R3: Bits [1:0] of register 0x1F give the bank, bank = bit1*2 + bit0, for addresses 0x00–0x1A. Addresses 0x1B–0x1F reach the same registers in every bank.
- R4: For a read of an address that is not slow-class, the value appears in `tx_byte` after the header, so it is sent in the second byte of the frame. Every later byte of that frame is 0x00.
- R5: Slow-class addresses are bank 2 0x00–0x1A and bank 3 0x00–0x05. A read of one of them sends 0x00 in the second byte and the value in the third byte, and 0x00 after that.
- R6: A register write stores the second byte of the frame. Bytes after the second are ignored.
- R7: A bit-set ORs the second byte into the register, and a bit-clear ANDs the register with the complement of the second byte. Both leave slow-class registers unchanged.
- R8: Reserved addresses are banks 0 and 1 at 0x18–0x1A and bank 3 at 0x10–0x1A. They ignore writes, bit-sets and bit-clears, and they read as 0x00.
- R9: A reset frame (header 0xFF) clears bits [1:0] of register 0x1F and keeps bits [7:2].
- R10: In bank 0, addresses 0x00/0x01 are the low/high bytes of the buffer read pointer and 0x02/0x03 are the low/high bytes of the buffer write pointer. A write or bit operation to one of them loads it, and a read returns it. Pointer bits above log2(buffer depth) read as 0.
- R11: Each byte after a 0x7A header is stored at the write pointer, and the pointer then increments modulo the buffer depth.
- R12: After a 0x3A header, `tx_byte` holds the buffer byte at the read pointer. Each further byte advances the read pointer by one modulo the depth and presents the byte at the new pointer.
- R13: A byte strobed in the same cycle as `cs_rise` still takes effect before the frame closes. A byte strobed in the same cycle as `cs_fall` is the header of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | One-cycle pulse: chip select asserted, frame begins |
| cs_rise | input | 1 | One-cycle pulse: chip select released, frame ends |
| rx_valid | input | 1 | One-cycle strobe: a MOSI byte is complete |
| rx_byte | input | 8 | The completed MOSI byte |
| tx_byte | output | 8 | Byte to shift out on MISO during the next byte period |

## Verification
The functions that can fall in the same cycle are a byte strobe and a frame boundary. The final data byte of a write can arrive together with the chip-select release, and a header can arrive together with the chip-select assertion. The bench drives both coincidences on purpose. It judges them by reading the target register back in a later, ordinary frame: the stored value must be the coincident byte. In the same frame, a read header strobed with `cs_fall` must return that value in the second byte. A stray byte right after the close must leave the bank bits unchanged.

// File: rtl/spibank_pkg.sv
package spibank_pkg;

   typedef enum logic [2:0] {
      OP_RDREG = 3'b000,
      OP_RDBUF = 3'b001,
      OP_WRREG = 3'b010,
      OP_WRBUF = 3'b011,
      OP_BSET  = 3'b100,
      OP_BCLR  = 3'b101,
      OP_NONE  = 3'b110,
      OP_RESET = 3'b111
   } op_e;

   localparam int          ADDR_W     = 5;
   localparam int          SPACE      = 1 << ADDR_W;
   localparam logic [7:0]  HDR_RDBUF  = 8'h3A;
   localparam logic [7:0]  HDR_WRBUF  = 8'h7A;
   localparam logic [7:0]  HDR_RESET  = 8'hFF;
   localparam logic [4:0]  CTRL_ADDR  = 5'h1F;
   localparam int          NPTR_REGS  = 4;

endpackage

// File: rtl/spibank_frame.sv
module spibank_frame
   import spibank_pkg::*;
#(
   parameter int POS_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              hdr_stb,
   output logic              data_stb,
   output logic [POS_W-1:0]  pos,
   output op_e               op,
   output logic [ADDR_W-1:0] addr,
   output logic              cmd_ok
);

   localparam logic [POS_W-1:0] POS_MAX = '1;

   generate
      if (POS_W < 2) begin : g_bad_pos
         $error("spibank_frame: POS_W must be at least 2");
      end
   endgenerate

   logic              active_q;
   logic [POS_W-1:0]  pos_q;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ok_q;

   logic              live;
   logic [POS_W-1:0]  pos_eff;
   op_e               hdr_op;
   logic              hdr_ok;

   assign live     = cs_fall | active_q;
   assign pos_eff  = cs_fall ? '0 : pos_q;
   assign hdr_stb  = rx_valid && live && (pos_eff == '0);
   assign data_stb = rx_valid && live && (pos_eff != '0);
   assign hdr_op   = op_e'(rx_byte[7:5]);

   always_comb begin
      unique case (hdr_op)
         OP_RDBUF: hdr_ok = (rx_byte == HDR_RDBUF);
         OP_WRBUF: hdr_ok = (rx_byte == HDR_WRBUF);
         OP_RESET: hdr_ok = (rx_byte == HDR_RESET);
         OP_NONE:  hdr_ok = 1'b0;
         default:  hdr_ok = 1'b1;
      endcase
   end

   assign pos    = pos_eff;
   assign op     = hdr_stb ? hdr_op : op_q;
   assign addr   = hdr_stb ? rx_byte[ADDR_W-1:0] : addr_q;
   assign cmd_ok = hdr_stb ? hdr_ok : ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pos_q    <= '0;
         op_q     <= OP_NONE;
         addr_q   <= '0;
         ok_q     <= 1'b0;
      end else begin
         active_q <= live && !cs_rise;
         if (cs_rise)
            pos_q <= '0;
         else if (rx_valid && live && (pos_eff != POS_MAX))
            pos_q <= pos_eff + 1'b1;
         else
            pos_q <= pos_eff;
         if (hdr_stb) begin
            op_q   <= hdr_op;
            addr_q <= rx_byte[ADDR_W-1:0];
         end
         if (cs_rise)
            ok_q <= 1'b0;
         else if (hdr_stb)
            ok_q <= hdr_ok;
      end
   end

endmodule

// File: rtl/spibank_regs.sv
module spibank_regs
   import spibank_pkg::*;
#(
   parameter int                   NBANK       = 4,
   parameter int                   SHARED_BASE = 27,
   parameter logic [NBANK*32-1:0]  SLOW_MASK   = '0,
   parameter logic [NBANK*32-1:0]  RSVD_MASK   = '0,
   localparam int                  BSEL_W      = (NBANK > 1) ? $clog2(NBANK) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              bank_clr,
   output logic [7:0]        rd_data,
   output logic              is_slow,
   output logic              is_rsvd,
   output logic [BSEL_W-1:0] bank
);

   localparam int NSHARED  = SPACE - SHARED_BASE;
   localparam int NREG     = NBANK * SHARED_BASE + NSHARED;
   localparam int IDX_W    = $clog2(NREG);
   localparam int CTRL_IDX = NBANK * SHARED_BASE + (SPACE - 1 - SHARED_BASE);
   localparam int MIDX_W   = BSEL_W + ADDR_W;

   generate
      if (NBANK < 2 || NBANK > 4 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
         $error("spibank_regs: NBANK must be 2 or 4");
      end
      if (SHARED_BASE < NPTR_REGS || SHARED_BASE > SPACE - 1) begin : g_bad_base
         $error("spibank_regs: SHARED_BASE out of range");
      end
   endgenerate

   logic [7:0]        regs_q [NREG];
   logic [IDX_W-1:0]  lin_idx;
   logic              shared_hit;
   logic [MIDX_W-1:0] mask_idx;
   logic [7:0]        ctrl;

   assign shared_hit = (int'(addr) >= SHARED_BASE);
   assign mask_idx   = {bank, addr};

   always_comb begin
      if (shared_hit)
         lin_idx = IDX_W'(NBANK * SHARED_BASE + int'(addr) - SHARED_BASE);
      else
         lin_idx = IDX_W'(int'(bank) * SHARED_BASE + int'(addr));
   end

   assign is_slow = !shared_hit && SLOW_MASK[mask_idx];
   assign is_rsvd = !shared_hit && RSVD_MASK[mask_idx];
   assign rd_data = is_rsvd ? 8'h00 : regs_q[lin_idx];
   assign ctrl    = regs_q[CTRL_IDX];

   generate
      if (NBANK > 1) begin : g_bank_bits
         assign bank = ctrl[BSEL_W-1:0];
      end else begin : g_bank_fixed
         assign bank = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
      end else begin
         if (wr_en && !is_rsvd)
            regs_q[lin_idx] <= wr_data;
         else if (bank_clr)
            regs_q[CTRL_IDX][BSEL_W-1:0] <= '0;
      end
   end

endmodule

// File: rtl/spibank_buf.sv
module spibank_buf #(
   parameter int  DEPTH = 32,
   localparam int AW    = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [7:0]    wr_data,
   input  logic          rd_adv,
   input  logic          ld_en,
   input  logic [1:0]    ptr_sel,
   input  logic [7:0]    ld_data,
   output logic [7:0]    rd_cur,
   output logic [7:0]    rd_nxt,
   output logic [7:0]    ptr_byte,
   output logic [AW-1:0] rdptr,
   output logic [AW-1:0] wrptr
);

   generate
      if (DEPTH < 2 || DEPTH > 1024 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spibank_buf: DEPTH must be a power of two from 2 to 1024");
      end
   endgenerate

   logic [7:0]    mem_q [DEPTH];
   logic [AW-1:0] rdptr_q;
   logic [AW-1:0] wrptr_q;
   logic [AW-1:0] rd_succ;

   assign rd_succ = rdptr_q + 1'b1;
   assign rd_cur  = mem_q[rdptr_q];
   assign rd_nxt  = mem_q[rd_succ];
   assign rdptr   = rdptr_q;
   assign wrptr   = wrptr_q;

   always_comb begin
      unique case (ptr_sel)
         2'd0: ptr_byte = 8'(rdptr_q);
         2'd1: ptr_byte = 8'(16'(rdptr_q) >> 8);
         2'd2: ptr_byte = 8'(wrptr_q);
         default: ptr_byte = 8'(16'(wrptr_q) >> 8);
      endcase
   end

   always_ff @(posedge clk) begin
      if (wr_stb) mem_q[wrptr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdptr_q <= '0;
         wrptr_q <= '0;
      end else begin
         if (ld_en) begin
            unique case (ptr_sel)
               2'd0: rdptr_q <= AW'({8'(16'(rdptr_q) >> 8), ld_data});
               2'd1: rdptr_q <= AW'({ld_data, 8'(rdptr_q)});
               2'd2: wrptr_q <= AW'({8'(16'(wrptr_q) >> 8), ld_data});
               default: wrptr_q <= AW'({ld_data, 8'(wrptr_q)});
            endcase
         end else begin
            if (rd_adv) rdptr_q <= rd_succ;
            if (wr_stb) wrptr_q <= wrptr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/spibank_regfile.sv
module spibank_regfile
   import spibank_pkg::*;
#(
   parameter int                   NBANK       = 4,
   parameter int                   SHARED_BASE = 27,
   parameter int                   BUF_DEPTH   = 32,
   parameter logic [NBANK*32-1:0]  SLOW_MASK   = {32'h0000_003F, 32'h07FF_FFFF,
                                                  32'h0000_0000, 32'h0000_0000},
   parameter logic [NBANK*32-1:0]  RSVD_MASK   = {32'h07FF_0000, 32'h0000_0000,
                                                  32'h0700_0000, 32'h0700_0000}
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_fall,
   input  logic       cs_rise,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   output logic [7:0] tx_byte
);

   localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int BUF_AW = $clog2(BUF_DEPTH);
   localparam int POS_W  = 2;

   logic              hdr_stb, data_stb, cmd_ok;
   logic [POS_W-1:0]  pos;
   op_e               op;
   logic [ADDR_W-1:0] addr;

   logic [7:0]        reg_rd;
   logic              is_slow, is_rsvd;
   logic [BSEL_W-1:0] bank_sel;
   logic              reg_wr, bank_clr;
   logic [7:0]        cur_val, mod_val;
   logic              is_ptr, bit_op, mod_go;

   logic              buf_wr, buf_adv, ptr_ld;
   logic [7:0]        buf_cur, buf_nxt, ptr_byte;
   logic [BUF_AW-1:0] rdptr, wrptr;
   logic [15:0]       rdptr16, wrptr16, ptr_mask;

   logic [7:0]        tx_q, tx_nxt;

   spibank_frame #(.POS_W(POS_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .hdr_stb(hdr_stb), .data_stb(data_stb), .pos(pos), .op(op),
      .addr(addr), .cmd_ok(cmd_ok)
   );

   spibank_regs #(
      .NBANK(NBANK), .SHARED_BASE(SHARED_BASE),
      .SLOW_MASK(SLOW_MASK), .RSVD_MASK(RSVD_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(reg_wr),
      .wr_data(mod_val), .bank_clr(bank_clr), .rd_data(reg_rd),
      .is_slow(is_slow), .is_rsvd(is_rsvd), .bank(bank_sel)
   );

   spibank_buf #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_stb(buf_wr), .wr_data(rx_byte),
      .rd_adv(buf_adv), .ld_en(ptr_ld), .ptr_sel(addr[1:0]),
      .ld_data(mod_val), .rd_cur(buf_cur), .rd_nxt(buf_nxt),
      .ptr_byte(ptr_byte), .rdptr(rdptr), .wrptr(wrptr)
   );

   // bank 0 low addresses map onto the buffer pointers
   assign is_ptr  = (bank_sel == '0) && (int'(addr) < NPTR_REGS);
   assign cur_val = is_ptr ? ptr_byte : reg_rd;
   assign bit_op  = (op == OP_BSET) || (op == OP_BCLR);

   always_comb begin
      unique case (op)
         OP_BSET: mod_val = cur_val | rx_byte;
         OP_BCLR: mod_val = cur_val & ~rx_byte;
         default: mod_val = rx_byte;
      endcase
   end

   assign mod_go   = data_stb && (pos == POS_W'(1)) && cmd_ok &&
                     ((op == OP_WRREG) || (bit_op && !is_slow));
   assign reg_wr   = mod_go && !is_ptr;
   assign ptr_ld   = mod_go && is_ptr;
   assign bank_clr = hdr_stb && cmd_ok && (op == OP_RESET);
   assign buf_wr   = data_stb && cmd_ok && (op == OP_WRBUF);
   assign buf_adv  = data_stb && cmd_ok && (op == OP_RDBUF);

   always_comb begin
      tx_nxt = 8'h00;
      if (hdr_stb && cmd_ok) begin
         if (op == OP_RDREG && !is_slow) tx_nxt = cur_val;
         else if (op == OP_RDBUF)        tx_nxt = buf_cur;
      end else if (data_stb && cmd_ok) begin
         if (op == OP_RDREG && is_slow && pos == POS_W'(1)) tx_nxt = cur_val;
         else if (op == OP_RDBUF)                           tx_nxt = buf_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tx_q <= 8'h00;
      else if (hdr_stb || data_stb)  tx_q <= tx_nxt;
   end

   assign tx_byte  = tx_q;
   assign rdptr16  = 16'(rdptr);
   assign wrptr16  = 16'(wrptr);
   assign ptr_mask = 16'(BUF_DEPTH - 1);

endmodule

// File: rtl/spibank_regfile_chk.sv
module spibank_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic [7:0]  rx_byte,
   input logic [7:0]  tx_byte,
   input logic        hdr_stb,
   input logic        data_stb,
   input logic [1:0]  bank_lo,
   input logic        buf_adv,
   input logic        buf_wr,
   input logic [15:0] rdptr16,
   input logic [15:0] wrptr16,
   input logic [15:0] ptr_mask
);

   // R1
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(tx_byte));

   // R2
   one_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_stb |-> !data_stb);

   // R9
   reset_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_stb && rx_byte == 8'hFF) |=> (bank_lo == 2'b00));

   // R12
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_adv |=> (rdptr16 == (($past(rdptr16) + 16'd1) & ptr_mask)));

   // R11
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |=> (wrptr16 == (($past(wrptr16) + 16'd1) & ptr_mask)));

   // R10
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_stb |=> ($stable(rdptr16) && $stable(wrptr16)));

endmodule

bind spibank_regfile spibank_regfile_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
   .tx_byte(tx_byte), .hdr_stb(hdr_stb), .data_stb(data_stb),
   .bank_lo(2'(bank_sel)), .buf_adv(buf_adv), .buf_wr(buf_wr),
   .rdptr16(rdptr16), .wrptr16(wrptr16), .ptr_mask(ptr_mask)
);

// File: tb/spibank_regfile_bench.sv
module spibank_regfile_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_fall = 1'b0, cs_rise = 1'b0, rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [7:0] tx_byte;

   int   n_vec = 0, n_bad = 0;
   bit   done = 1'b0;
   logic [7:0] mo [8];
   logic [7:0] mi [8];

   always #10 clk = ~clk;

   spibank_regfile u_spibank_regfile (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte)
   );

   function automatic bit slow_f(int b, int a);
      return (b == 2 && a <= 26) || (b == 3 && a <= 5);
   endfunction

   function automatic bit rsvd_f(int b, int a);
      return ((b == 0 || b == 1) && a >= 24 && a <= 26) || (b == 3 && a >= 16 && a <= 26);
   endfunction

   function automatic logic [7:0] pat(int b, int a);
      return 8'((b * 53 + a * 7 + 3) & 255);
   endfunction

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic xfer(logic [7:0] b, bit fall, bit rise, output logic [7:0] so);
      so = tx_byte;
      rx_byte = b; rx_valid = 1'b1; cs_fall = fall; cs_rise = rise;
      @(negedge clk);
      rx_valid = 1'b0; cs_fall = 1'b0; cs_rise = 1'b0;
   endtask

   task automatic pulse_fall();
      cs_fall = 1'b1; @(negedge clk); cs_fall = 1'b0;
   endtask

   task automatic pulse_rise();
      cs_rise = 1'b1; @(negedge clk); cs_rise = 1'b0;
   endtask

   task automatic frame(int n);
      pulse_fall();
      for (int i = 0; i < n; i++) xfer(mo[i], 1'b0, 1'b0, mi[i]);
      pulse_rise();
   endtask

   task automatic wr_reg(logic [4:0] a, logic [7:0] d);
      mo[0] = {3'b010, a}; mo[1] = d; frame(2);
   endtask

   task automatic bit_op(bit set, logic [4:0] a, logic [7:0] d);
      mo[0] = {set ? 3'b100 : 3'b101, a}; mo[1] = d; frame(2);
   endtask

   // three-byte read: mi[1] and mi[2] hold the MISO bytes
   task automatic rd_reg(logic [4:0] a);
      mo[0] = {3'b000, a}; mo[1] = 8'h00; mo[2] = 8'h00; frame(3);
   endtask

   task automatic bank(int b);
      wr_reg(5'h1F, 8'(b));
   endtask

   initial begin
      logic [7:0] so;
      logic [7:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 reset tx", tx_byte, 8'h00);
      rd_reg(5'h1F);
      chk("R1 reset ctrl", mi[1], 8'h00);

      // R6 sweep writes over every bank and banked address
      for (int b = 0; b < 4; b++) begin
         bank(b);
         for (int a = 0; a < 27; a++)
            if (!(b == 0 && a < 4)) wr_reg(5'(a), pat(b, a));
      end
      // R3 R4 R5 R8 read back sweep
      for (int b = 0; b < 4; b++) begin
         bank(b);
         for (int a = 0; a < 27; a++) begin
            if (b == 0 && a < 4) continue;
            e = rsvd_f(b, a) ? 8'h00 : pat(b, a);
            rd_reg(5'(a));
            if (slow_f(b, a)) begin
               chk("R5 dummy", mi[1], 8'h00);
               chk("R5 value", mi[2], e);
            end else begin
               chk(rsvd_f(b, a) ? "R8 reserved" : "R4 value", mi[1], e);
               chk("R4 trailing", mi[2], 8'h00);
            end
         end
      end

      // R3 shared registers seen in every bank
      bank(3);
      wr_reg(5'h1C, 8'h5A);
      wr_reg(5'h1E, 8'hC3);
      for (int b = 0; b < 3; b++) begin
         bank(b);
         rd_reg(5'h1C); chk("R3 shared 1C", mi[1], 8'h5A);
         rd_reg(5'h1E); chk("R3 shared 1E", mi[1], 8'hC3);
      end

      // R7 bit set / clear
      bank(1);
      bit_op(1'b1, 5'd5, 8'h0F);
      rd_reg(5'd5); chk("R7 set", mi[1], pat(1, 5) | 8'h0F);
      bit_op(1'b0, 5'd5, 8'h33);
      rd_reg(5'd5); chk("R7 clear", mi[1], (pat(1, 5) | 8'h0F) & ~8'h33);
      bank(2);
      bit_op(1'b1, 5'd3, 8'hFF);
      rd_reg(5'd3); chk("R7 slow set ignored", mi[2], pat(2, 3));
      bit_op(1'b0, 5'd3, 8'hFF);
      rd_reg(5'd3); chk("R7 slow clear ignored", mi[2], pat(2, 3));
      bank(0);
      bit_op(1'b1, 5'd25, 8'hFF);
      rd_reg(5'd25); chk("R8 reserved set ignored", mi[1], 8'h00);

      // R6 extra bytes ignored
      bank(1);
      mo[0] = 8'h46; mo[1] = 8'h11; mo[2] = 8'h22; mo[3] = 8'h33; frame(4);
      rd_reg(5'd6); chk("R6 extra ignored", mi[1], 8'h11);

      // R9 reset keeps upper bits
      wr_reg(5'h1F, 8'hA6);
      mo[0] = 8'hFF; frame(1);
      rd_reg(5'h1F); chk("R9 bank cleared", mi[1], 8'hA4);
      rd_reg(5'd6);  chk("R9 now bank 0", mi[1], pat(0, 6));

      // R10 pointer registers
      bank(0);
      wr_reg(5'h02, 8'd30);
      wr_reg(5'h03, 8'h12);
      rd_reg(5'h03); chk("R10 high bits zero", mi[1], 8'h00);
      rd_reg(5'h02); chk("R10 wr ptr", mi[1], 8'd30);

      // R11 buffer write with wrap
      mo[0] = 8'h7A;
      for (int i = 0; i < 5; i++) mo[i + 1] = 8'(8'hB0 + i * 9);
      frame(6);
      rd_reg(5'h02); chk("R11 wr ptr wrap", mi[1], 8'd3);

      // R12 buffer read with wrap
      wr_reg(5'h00, 8'd30);
      mo[0] = 8'h3A;
      for (int i = 1; i < 5; i++) mo[i] = 8'h00;
      frame(5);
      for (int i = 0; i < 4; i++) chk("R12 buffer data", mi[i + 1], 8'(8'hB0 + i * 9));
      rd_reg(5'h00); chk("R12 rd ptr wrap", mi[1], 8'd2);

      // R2 malformed buffer headers are inert
      mo[0] = 8'h3B; mo[1] = 8'h00; mo[2] = 8'h00; frame(3);
      chk("R2 bad read hdr", mi[1], 8'h00);
      chk("R2 bad read hdr 2", mi[2], 8'h00);
      mo[0] = 8'h7B; mo[1] = 8'h55; frame(2);
      rd_reg(5'h02); chk("R2 bad write hdr", mi[1], 8'd3);
      rd_reg(5'h00); chk("R2 rd ptr untouched", mi[1], 8'd2);
      mo[0] = 8'hC5; mo[1] = 8'h00; frame(2);
      chk("R2 op 110", mi[1], 8'h00);
      mo[0] = 8'hFE; frame(1);
      bank(1); mo[0] = 8'hFE; frame(1);
      rd_reg(5'h1F); chk("R2 near-reset ignored", mi[1], 8'h01);

      // R1 byte outside a frame
      e = tx_byte;
      xfer(8'hFF, 1'b0, 1'b0, so);
      chk("R1 idle tx held", tx_byte, e);
      xfer(8'h40 | 8'h1F, 1'b0, 1'b0, so);
      xfer(8'h03, 1'b0, 1'b0, so);
      rd_reg(5'h1F); chk("R1 idle bytes ignored", mi[1], 8'h01);

      // R13 coincident boundaries
      pulse_fall();
      xfer(8'h47, 1'b0, 1'b0, so);
      xfer(8'h99, 1'b0, 1'b1, so);
      xfer(8'hFF, 1'b0, 1'b0, so);
      pulse_fall();
      xfer(8'h07, 1'b0, 1'b0, so);
      xfer(8'h00, 1'b0, 1'b1, so);
      chk("R13 close with byte", so, 8'h99);
      xfer(8'h00, 1'b1, 1'b0, so);
      pulse_rise();
      mo[0] = 8'h00; frame(0);
      pulse_fall();
      xfer(8'h07, 1'b1, 1'b0, so);
      xfer(8'h00, 1'b0, 1'b0, so);
      pulse_rise();
      chk("R13 header with open", so, 8'h99);
      rd_reg(5'h1F); chk("R13 stray byte ignored", mi[1], 8'h01);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog expired got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule